// File: doc/BRIEF.md
# Dataway Memory Command Controller

This block is the command side of a word-addressed memory that a host reaches through a crate dataway. Each host command arrives as a five-bit function code and a four-bit subaddress on a single strobe cycle. Only subaddress zero is decoded. The controller keeps an address register, which can step forward after each data access, and a read-ahead output register. It also holds an attention flag with its own enable, the two port-ownership bits, and the X (command recognised) and Q (command acted on) responses.

Reads come from the read-ahead register and never straight from the array. Loading the address fetches the word at that address. Each read hands out the buffered word, advances the address when stepping is on, and then fetches the next word. The memory array is outside the block, behind a synchronous single-port interface with one cycle of read latency. While the controller is writing or fetching it raises `busy`, and strobes that arrive during that time are dropped.

Top module: `dwMemCtrl`

## Requirements
- R1: After reset the address is zero, the attention flag and its enable are clear, the internal port owns the memory (`intPortEn`=1, `extPortEn`=0), address stepping is on, `respX`/`respQ`/`busy` are 0 and `rdData` is zero.
- R2: Code 18 loads the address from the low ADDR_W bits of `wrData` and fetches the word there into the read-ahead register. It answers X=1 and Q=1 while the internal port is enabled, and then `busy` is high for exactly 2 cycles.
- R3: Code 2 puts the read-ahead word on `rdData`, advances the address if stepping is on, and refetches. Reads that follow a code 18 therefore return consecutive words, starting with the word at the loaded address. X=1 and Q=1 while the internal port is enabled.
- R4: Code 16 writes `wrData` to the current address and then advances the address if stepping is on. Stepping past the all-ones address wraps to zero. `busy` is high for exactly 1 cycle afterwards.
- R5: Code 17 turns stepping off and code 25 turns it back on. With stepping off, repeated reads return the same word and repeated writes hit the same address.
- R6: Code 0 places the address, zero-extended, on `rdData` and answers X=1, Q=0.
- R7: A read or write at the all-ones address sets the attention flag (`lamOut`) only while its enable is on. Code 26 enables it, code 24 disables it, and code 10 clears it. Code 8 answers Q=1 only while the flag is set.
- R8: Code 9 sets the address to zero, clears and disables the attention flag, hands the memory to the internal port and turns stepping on. A high `initPulse` does the same except that it keeps the address, and it also clears `respX`/`respQ`.
- R9: Exactly one port owns the memory. Code 11 gives it to the external port and code 19 returns it to the internal port. While the external port owns it, codes 2, 16 and 18 answer X=1, Q=0 and change neither the address nor the memory.
- R10: A code outside {0,2,8,9,10,11,16,17,18,19,24,25,26}, or any nonzero subaddress, answers X=0, Q=0 and changes no state.
- R11: A strobe that arrives while `busy` is high is ignored. The responses and all state stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStrobe | input | 1 | One-cycle command strobe |
| funcCode | input | 5 | Function code |
| subAddr | input | 4 | Subaddress; only 0 is decoded |
| wrData | input | DATA_W | Host write lines |
| initPulse | input | 1 | Crate initialise, overrides any command in the same cycle |
| rdData | output | DATA_W | Host read lines, updated by codes 0 and 2 |
| respX | output | 1 | Command recognised |
| respQ | output | 1 | Command acted on / attention test result |
| lamOut | output | 1 | Attention flag |
| intPortEn | output | 1 | Internal (host) port owns the memory |
| extPortEn | output | 1 | External port owns the memory |
| busy | output | 1 | Memory cycle in progress; strobes are ignored |
| memAddr | output | ADDR_W | Memory address |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, one cycle after memRe |

## Verification
The attention flag is the hardest case to reach, because it needs a real access at the very last address while the enable is in a chosen state. The bench uses a narrow address configuration. A full write sweep and a full read sweep cross the wrap point with the flag disabled. After that, directed sequences load the next-to-last address and step onto the last one by reads and by writes, with the enable turned on, turned off, and cleared by code 9 and by initialise. Strobes that land during a busy window are produced by pulsing a second command at the negative edge right after a load.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

  localparam logic [4:0] FC_RDADDR  = 5'd0;
  localparam logic [4:0] FC_READ    = 5'd2;
  localparam logic [4:0] FC_TESTLAM = 5'd8;
  localparam logic [4:0] FC_CLEAR   = 5'd9;
  localparam logic [4:0] FC_CLRLAM  = 5'd10;
  localparam logic [4:0] FC_EXTON   = 5'd11;
  localparam logic [4:0] FC_WRITE   = 5'd16;
  localparam logic [4:0] FC_INCOFF  = 5'd17;
  localparam logic [4:0] FC_LDADDR  = 5'd18;
  localparam logic [4:0] FC_EXTOFF  = 5'd19;
  localparam logic [4:0] FC_LAMOFF  = 5'd24;
  localparam logic [4:0] FC_INCON   = 5'd25;
  localparam logic [4:0] FC_LAMON   = 5'd26;

  // strobes from control to datapath
  typedef struct packed {
    logic ldAddr;   // load address from write lines
    logic clrAddr;  // force address to zero
    logic incAddr;  // step address
    logic latchWr;  // capture write data and access address
    logic capOut;   // read-ahead word to host read lines
    logic capAddr;  // address to host read lines
    logic memRd;    // issue array read at address
    logic memWr;    // issue array write from latches
    logic loadOut;  // capture array data into read-ahead register
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_FETCH = 2'd2,
    ST_LOAD  = 2'd3
  } ctrlState_t;

  function automatic logic knownCode(input logic [4:0] f);
    case (f)
      FC_RDADDR, FC_READ, FC_TESTLAM, FC_CLEAR, FC_CLRLAM, FC_EXTON,
      FC_WRITE, FC_INCOFF, FC_LDADDR, FC_EXTOFF, FC_LAMOFF, FC_INCON,
      FC_LAMON: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dwmDatapath.sv
module dwmDatapath
  import dwm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              atLast
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] accAddr;
  logic [DATA_W-1:0] wrLatch;
  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] addrWide;

  generate
    if (DATA_W > ADDR_W) begin : g_pad
      assign addrWide = {{(DATA_W-ADDR_W){1'b0}}, addr};
    end else begin : g_fit
      assign addrWide = addr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (strb.clrAddr) begin
      addr <= '0;
    end else if (strb.ldAddr) begin
      addr <= wrData[ADDR_W-1:0];
    end else if (strb.incAddr) begin
      addr <= addr + ADDR_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accAddr <= '0;
      wrLatch <= '0;
    end else if (strb.latchWr) begin
      accAddr <= addr;
      wrLatch <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strb.loadOut) begin
      outReg <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.capOut) begin
      rdData <= outReg;
    end else if (strb.capAddr) begin
      rdData <= addrWide;
    end
  end

  always_comb begin
    memAddr  = strb.memWr ? accAddr : addr;
    memWe    = strb.memWr;
    memRe    = strb.memRd;
    memWdata = wrLatch;
    atLast   = &addr;
  end

endmodule

// File: rtl/dwmCtrl.sv
module dwmCtrl
  import dwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdStrobe,
  input  logic [4:0] funcCode,
  input  logic [3:0] subAddr,
  input  logic      initPulse,
  input  logic      atLast,
  output dpStrobe_t strb,
  output logic      respX,
  output logic      respQ,
  output logic      lamOut,
  output logic      intPortEn,
  output logic      extPortEn,
  output logic      busy
);

  ctrlState_t state, nextState;
  logic lamEn, autoInc;
  logic accept, valid, memCmd, qVal;
  logic doRead, doWrite, doLoad;

  always_comb begin
    busy    = (state != ST_IDLE);
    accept  = cmdStrobe && !busy && !initPulse;
    valid   = accept && (subAddr == 4'd0) && knownCode(funcCode);
    memCmd  = (funcCode == FC_READ) || (funcCode == FC_WRITE) ||
              (funcCode == FC_LDADDR);
    doRead  = valid && intPortEn && (funcCode == FC_READ);
    doWrite = valid && intPortEn && (funcCode == FC_WRITE);
    doLoad  = valid && intPortEn && (funcCode == FC_LDADDR);
    qVal    = valid && ((memCmd && intPortEn) ||
                        ((funcCode == FC_TESTLAM) && lamOut));
  end

  always_comb begin
    strb         = '0;
    strb.ldAddr  = doLoad;
    strb.clrAddr = valid && (funcCode == FC_CLEAR);
    strb.incAddr = (doRead || doWrite) && autoInc;
    strb.latchWr = doWrite;
    strb.capOut  = doRead;
    strb.capAddr = valid && (funcCode == FC_RDADDR);
    strb.memRd   = (state == ST_FETCH);
    strb.memWr   = (state == ST_WRITE);
    strb.loadOut = (state == ST_LOAD);
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (doWrite)                nextState = ST_WRITE;
        else if (doRead || doLoad)  nextState = ST_FETCH;
      end
      ST_WRITE: nextState = ST_IDLE;
      ST_FETCH: nextState = ST_LOAD;
      ST_LOAD:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN || initPulse) begin
      lamOut    <= 1'b0;
      lamEn     <= 1'b0;
      intPortEn <= 1'b1;
      extPortEn <= 1'b0;
      autoInc   <= 1'b1;
      respX     <= 1'b0;
      respQ     <= 1'b0;
    end else if (accept) begin
      respX <= valid;
      respQ <= qVal;
      if ((doRead || doWrite) && atLast && lamEn) lamOut <= 1'b1;
      if (valid) begin
        case (funcCode)
          FC_CLEAR: begin
            lamOut    <= 1'b0;
            lamEn     <= 1'b0;
            intPortEn <= 1'b1;
            extPortEn <= 1'b0;
            autoInc   <= 1'b1;
          end
          FC_CLRLAM: lamOut <= 1'b0;
          FC_LAMOFF: lamEn  <= 1'b0;
          FC_LAMON:  lamEn  <= 1'b1;
          FC_INCOFF: autoInc <= 1'b0;
          FC_INCON:  autoInc <= 1'b1;
          FC_EXTON: begin
            extPortEn <= 1'b1;
            intPortEn <= 1'b0;
          end
          FC_EXTOFF: begin
            extPortEn <= 1'b0;
            intPortEn <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dwMemCtrl.sv
module dwMemCtrl
  import dwm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStrobe,
  input  logic [4:0]        funcCode,
  input  logic [3:0]        subAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              initPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              respX,
  output logic              respQ,
  output logic              lamOut,
  output logic              intPortEn,
  output logic              extPortEn,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  dpStrobe_t strb;
  logic atLast;

  dwmCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStrobe (cmdStrobe),
    .funcCode  (funcCode),
    .subAddr   (subAddr),
    .initPulse (initPulse),
    .atLast    (atLast),
    .strb      (strb),
    .respX     (respX),
    .respQ     (respQ),
    .lamOut    (lamOut),
    .intPortEn (intPortEn),
    .extPortEn (extPortEn),
    .busy      (busy)
  );

  dwmDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memRe    (memRe),
    .memWdata (memWdata),
    .rdData   (rdData),
    .atLast   (atLast)
  );

endmodule

// File: rtl/dwmChecker.sv
module dwmChecker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdStrobe,
  input logic [4:0] funcCode,
  input logic [3:0] subAddr,
  input logic       initPulse,
  input logic       respX,
  input logic       respQ,
  input logic       lamOut,
  input logic       intPortEn,
  input logic       extPortEn,
  input logic       busy,
  input logic       memWe
);

  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPortEn != extPortEn);

  // R10
  invalid_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && !busy && !initPulse && subAddr != 4'd0) |=> (!respX && !respQ));

  // R8
  init_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    initPulse |=> (!lamOut && intPortEn && !extPortEn && !respX && !respQ));

  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && !busy && !initPulse && subAddr == 4'd0 &&
     funcCode == 5'd18 && intPortEn) |=> busy);

  // R7
  lam_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lamOut) |-> $past(cmdStrobe && !busy));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && busy && !initPulse) |=> ($stable(respX) && $stable(respQ)));

  // R4
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

endmodule

bind dwMemCtrl dwmChecker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cmdStrobe (cmdStrobe),
  .funcCode  (funcCode),
  .subAddr   (subAddr),
  .initPulse (initPulse),
  .respX     (respX),
  .respQ     (respQ),
  .lamOut    (lamOut),
  .intPortEn (intPortEn),
  .extPortEn (extPortEn),
  .busy      (busy),
  .memWe     (memWe)
);

// File: tb/dwMemCtrl_tb_top.sv
`timescale 1ns/1ps
module dwMemCtrl_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LASTA = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStrobe = 1'b0;
  logic [4:0] funcCode = '0;
  logic [3:0] subAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic initPulse = 1'b0;
  logic [DW-1:0] rdData;
  logic respX, respQ, lamOut, intPortEn, extPortEn, busy;
  logic [AW-1:0] memAddr;
  logic memWe, memRe;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;

  logic [DW-1:0] ram [DEPTH];

  int checks = 0;
  int errors = 0;
  int lastBusy = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (memWe) ram[memAddr] <= memWdata;
    if (memRe) memRdata <= ram[memAddr];
  end

  dwMemCtrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdStrobe(cmdStrobe), .funcCode(funcCode),
    .subAddr(subAddr), .wrData(wrData), .initPulse(initPulse),
    .rdData(rdData), .respX(respX), .respQ(respQ), .lamOut(lamOut),
    .intPortEn(intPortEn), .extPortEn(extPortEn), .busy(busy),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 945 + 29) ^ 16'hA500);
  endfunction

  function automatic bit isKnown(input int f);
    return f == 0 || f == 2 || f == 8 || f == 9 || f == 10 || f == 11 ||
           f == 16 || f == 17 || f == 18 || f == 19 || f == 24 || f == 25 ||
           f == 26;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input int f, input int sa, input logic [DW-1:0] wd);
    int n = 0;
    @(negedge clk);
    cmdStrobe = 1'b1;
    funcCode  = 5'(f);
    subAddr   = 4'(sa);
    wrData    = wd;
    @(negedge clk);
    cmdStrobe = 1'b0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    lastBusy = n;
  endtask

  task automatic addrIs(input string tag, input int a);
    cmd(0, 0, '0);
    chk(tag, rdData, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 respX", respX, 0);
    chk("R1 respQ", respQ, 0);
    chk("R1 lamOut", lamOut, 0);
    chk("R1 intPortEn", intPortEn, 1);
    chk("R1 extPortEn", extPortEn, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rdData", rdData, 0);
    cmd(0, 0, '0);
    chk("R6 addr read X", respX, 1);
    chk("R6 addr read Q", respQ, 0);
    chk("R1 R6 reset addr", rdData, 0);

    // R2 load address
    cmd(18, 0, '0);
    chk("R2 load X", respX, 1);
    chk("R2 load Q", respQ, 1);
    chk("R2 load busy cycles", lastBusy, 2);

    // R4 write sweep with wrap
    for (int a = 0; a < DEPTH; a++) begin
      cmd(16, 0, pat(a));
      chk("R4 write Q", respQ, 1);
      if (a == 0) chk("R4 write busy cycles", lastBusy, 1);
    end
    addrIs("R4 wrap to zero", 0);
    chk("R7 no flag when disabled", lamOut, 0);

    // R3 read sweep
    cmd(18, 0, '0);
    for (int a = 0; a < DEPTH; a++) begin
      cmd(2, 0, '0);
      chk("R3 read data", rdData, pat(a));
      chk("R3 read Q", respQ, 1);
    end
    addrIs("R3 wrap after reads", 0);
    chk("R7 read wrap no flag", lamOut, 0);

    // R2 only low bits used, R6 zero-extended
    cmd(18, 0, 16'h1234);
    addrIs("R2 R6 low bits", 16'h0034);

    // R5 stepping off
    cmd(17, 0, '0);
    cmd(2, 0, '0);
    chk("R5 read1", rdData, pat(16'h34));
    cmd(2, 0, '0);
    chk("R5 read2", rdData, pat(16'h34));
    addrIs("R5 addr held on read", 16'h34);
    cmd(16, 0, 16'h1111);
    cmd(16, 0, 16'hBEEF);
    addrIs("R5 addr held on write", 16'h34);
    cmd(18, 0, 16'h34);
    cmd(2, 0, '0);
    chk("R5 last write wins", rdData, 16'hBEEF);
    cmd(25, 0, '0);
    cmd(2, 0, '0);
    addrIs("R5 stepping back on", 16'h35);

    // R7 attention flag
    cmd(26, 0, '0);
    cmd(18, 0, 16'hFE);
    cmd(2, 0, '0);
    chk("R7 no flag before last", lamOut, 0);
    cmd(8, 0, '0);
    chk("R7 test Q clear", respQ, 0);
    cmd(2, 0, '0);
    chk("R7 read at last data", rdData, pat(LASTA));
    chk("R7 flag on read", lamOut, 1);
    cmd(8, 0, '0);
    chk("R7 test Q set", respQ, 1);
    chk("R7 test X", respX, 1);
    cmd(10, 0, '0);
    chk("R7 clear", lamOut, 0);
    cmd(24, 0, '0);
    cmd(18, 0, 16'hFF);
    cmd(2, 0, '0);
    chk("R7 disabled no flag", lamOut, 0);
    cmd(26, 0, '0);
    cmd(18, 0, 16'hFF);
    cmd(16, 0, pat(LASTA));
    chk("R7 flag on write", lamOut, 1);
    // R8 clear command
    cmd(17, 0, '0);
    cmd(9, 0, '0);
    chk("R8 clear flag", lamOut, 0);
    addrIs("R8 clear addr", 0);
    cmd(18, 0, 16'hFF);
    cmd(2, 0, '0);
    chk("R8 enable dropped", lamOut, 0);
    addrIs("R8 stepping restored", 0);

    // R9 port ownership
    cmd(18, 0, 16'h20);
    cmd(11, 0, '0);
    chk("R9 ext on", extPortEn, 1);
    chk("R9 int off", intPortEn, 0);
    cmd(16, 0, 16'h7777);
    chk("R9 write X", respX, 1);
    chk("R9 write Q", respQ, 0);
    cmd(2, 0, '0);
    chk("R9 read Q", respQ, 0);
    cmd(18, 0, 16'h50);
    chk("R9 load Q", respQ, 0);
    addrIs("R9 addr untouched", 16'h20);
    cmd(19, 0, '0);
    chk("R9 int back", intPortEn, 1);
    chk("R9 ext off", extPortEn, 0);
    cmd(18, 0, 16'h20);
    cmd(2, 0, '0);
    chk("R9 memory untouched", rdData, pat(16'h20));
    cmd(11, 0, '0);
    cmd(9, 0, '0);
    chk("R8 clear gives internal", intPortEn, 1);
    chk("R8 clear drops external", extPortEn, 0);

    // R10 invalid codes and subaddresses
    cmd(18, 0, 16'h42);
    for (int f = 0; f < 32; f++) begin
      cmd(f, 3, 16'h00AA);
      chk("R10 subaddr X", respX, 0);
      chk("R10 subaddr Q", respQ, 0);
      if (!isKnown(f)) begin
        cmd(f, 0, 16'h00AA);
        chk("R10 code X", respX, 0);
        chk("R10 code Q", respQ, 0);
      end
    end
    chk("R10 ports kept", {intPortEn, extPortEn}, 2'b10);
    chk("R10 flag kept", lamOut, 0);
    addrIs("R10 addr kept", 16'h42);

    // R11 strobe during busy
    @(negedge clk);
    cmdStrobe = 1'b1; funcCode = 5'd18; subAddr = '0; wrData = 16'h40;
    @(negedge clk);
    funcCode = 5'd11;
    chk("R11 busy seen", busy, 1);
    @(negedge clk);
    cmdStrobe = 1'b0;
    while (busy) @(negedge clk);
    chk("R11 ignored ext", extPortEn, 0);
    chk("R11 resp kept X", respX, 1);
    chk("R11 resp kept Q", respQ, 1);
    addrIs("R11 addr from load", 16'h40);

    // R8 initialise
    cmd(26, 0, '0);
    cmd(18, 0, 16'hFF);
    cmd(2, 0, '0);
    chk("R8 flag set before init", lamOut, 1);
    cmd(17, 0, '0);
    cmd(11, 0, '0);
    @(negedge clk);
    initPulse = 1'b1;
    cmdStrobe = 1'b1; funcCode = 5'd26; subAddr = '0;
    @(negedge clk);
    initPulse = 1'b0;
    cmdStrobe = 1'b0;
    chk("R8 init flag", lamOut, 0);
    chk("R8 init int", intPortEn, 1);
    chk("R8 init ext", extPortEn, 0);
    chk("R8 init X", respX, 0);
    addrIs("R8 init keeps addr", 0);
    cmd(18, 0, 16'h10);
    cmd(2, 0, '0);
    addrIs("R8 init stepping on", 16'h11);
    cmd(18, 0, 16'hFF);
    cmd(2, 0, '0);
    chk("R8 init enable off", lamOut, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule